// File: doc/BRIEF.md
# Interrupt status and mask register unit

This block collects single-cycle event pulses from a serial transfer engine into an eight-bit sticky status register. Software clears status bits by writing ones to them. A software-written enable mask selects which latched events drive a single level interrupt line. One event, the packet-complete indication, drives the line whether or not it is enabled.

Software reaches the block through a simple register port. A write happens in the cycle that `wr_en_i` is high. A read is requested by `rd_en_i`, and its data appears on `rdata_o` one cycle later. A build-time parameter selects between two address layouts. The native layout puts the mask at 0x64 and the status at 0x68. The alternate layout moves every register at or above 0x50 up by 0x10 and every lower one up by 0x40. It also adds a separate done register at 0x0C, whose bit 30 is a sticky flag set by packet-complete.

Top module: `irq_status_unit`

## Requirements
- R1: An event pulse on `evt_i[k]` sets status bit k at the next clock edge, and the bit stays set until it is cleared. Bit meanings are: 0 receive-data-request, 1 transmit-data-request, 2 arbitration-lost, 3 no-acknowledge, 4 receive-underflow, 5 transmit-overflow, 6 all-packets-complete, 7 packet-complete.
- R2: A write to the status register clears every status bit whose write-data bit is 1. It leaves bits written with 0 unchanged. Writing 0xFF clears all bits.
- R3: If an event pulse arrives in the same cycle as a write that clears that bit, the bit stays set.
- R4: `irq_o` is registered. It is high in the cycle after any status bit is set together with its mask bit (mask bit k enables status bit k).
- R5: Status bit 7 (packet-complete) drives `irq_o` high one cycle later even when mask bit 7 is 0.
- R6: After reset, status, mask and the done flag are all zero, and `irq_o` is low.
- R7: A write to the mask register stores `wdata_i[7:0]`, and a read returns it in bits 7:0. A read of the status register returns the status in bits 7:0. The upper bits of both reads are zero. Native addresses are mask 0x64 and status 0x68. Alternate addresses are mask 0x74 and status 0x78.
- R8: In the alternate layout, bit 30 of the register at 0x0C is set by a packet-complete event and cleared by writing 1 to bit 30. An event arriving in the same cycle as the clear wins. In the native layout, 0x0C reads zero and writes to it have no effect.
- R9: A read returns data one cycle after `rd_en_i`. `rdata_o` is zero in the cycle after a cycle without a read, and after a read of an unmapped address. A write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | EVT_W | Event pulses, one bit per status bit |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The bench targets several collisions and edge cases:
- An event arriving in the same cycle as the write that clears it. A design that gives the clear priority would lose that event for good.
- Writes of zero bits to the status register. A design that stores the written value instead of clearing would wipe unrelated pending events.
- Packet-complete arriving with its mask bit cleared. A design that gates it through the mask would never signal the end of a transfer.
- Both address layouts run side by side. A wrong relocation offset shows up as zero or misplaced read data, and a done flag leaking into the native layout shows up as a nonzero read of 0x0C.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int EV_RX_REQ    = 0;
  localparam int EV_TX_REQ    = 1;
  localparam int EV_ARB_LOST  = 2;
  localparam int EV_NO_ACK    = 3;
  localparam int EV_RX_UNDER  = 4;
  localparam int EV_TX_OVER   = 5;
  localparam int EV_ALL_DONE  = 6;
  localparam int EV_PKT_DONE  = 7;

  localparam int OFS_MASK     = 'h64;
  localparam int OFS_STATUS   = 'h68;
  localparam int OFS_DONE     = 'h0C;
  localparam int HI_SPLIT     = 'h50;
  localparam int HI_SHIFT     = 'h10;
  localparam int LO_SHIFT     = 'h40;
  localparam int DONE_BIT     = 30;

  // Relocates a native offset into the alternate window when alt is set.
  function automatic int place(input int ofs, input int alt);
    if (alt == 0) return ofs;
    return ofs + ((ofs >= HI_SPLIT) ? HI_SHIFT : LO_SHIFT);
  endfunction
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode #(
  parameter int ADDR_W = 8,
  parameter int ALT    = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_mask,
  output logic              hit_status,
  output logic              hit_done
);
  localparam logic [ADDR_W-1:0] MASK_A =
    ADDR_W'(irq_regs_pkg::place(irq_regs_pkg::OFS_MASK, ALT));
  localparam logic [ADDR_W-1:0] STAT_A =
    ADDR_W'(irq_regs_pkg::place(irq_regs_pkg::OFS_STATUS, ALT));
  localparam logic [ADDR_W-1:0] DONE_A = ADDR_W'(irq_regs_pkg::OFS_DONE);

  assign hit_mask   = (addr == MASK_A);
  assign hit_status = (addr == STAT_A);

  generate
    if (ALT != 0) begin : g_alt
      assign hit_done = (addr == DONE_A);
    end else begin : g_nat
      assign hit_done = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] status
);
  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)
          status[b] <= 1'b0;
        else if (evt[b])
          status[b] <= 1'b1;
        else if (clr_en && clr_bits[b])
          status[b] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_done_flag.sv
module irq_done_flag #(
  parameter int ALT = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  generate
    if (ALT != 0) begin : g_alt
      always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
      end
    end else begin : g_nat
      logic unused_in;
      assign unused_in = clk ^ rst ^ set ^ clr;
      assign flag = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int EVT_W      = 8,
  parameter int ALT_LAYOUT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int BYP  = irq_regs_pkg::EV_PKT_DONE;
  localparam int DBIT = irq_regs_pkg::DONE_BIT;

  logic             hit_mask, hit_status, hit_done;
  logic [EVT_W-1:0] status_q, mask_q;
  logic             status_clr, done_q, done_clr;
  logic [DATA_W-1:0] rd_d;
  logic             unused_wbits;

  assign unused_wbits = ^wdata_i;

  irq_addr_decode #(.ADDR_W(ADDR_W), .ALT(ALT_LAYOUT)) u_dec (
    .addr(addr_i), .hit_mask(hit_mask), .hit_status(hit_status),
    .hit_done(hit_done)
  );

  assign status_clr = wr_en_i && hit_status;

  irq_status_bank #(.W(EVT_W)) u_bank (
    .clk(clk), .rst(rst), .evt(evt_i), .clr_en(status_clr),
    .clr_bits(wdata_i[EVT_W-1:0]), .status(status_q)
  );

  assign done_clr = wr_en_i && hit_done && wdata_i[DBIT];

  irq_done_flag #(.ALT(ALT_LAYOUT)) u_done (
    .clk(clk), .rst(rst), .set(evt_i[BYP]), .clr(done_clr), .flag(done_q)
  );

  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '0;
    else if (wr_en_i && hit_mask)
      mask_q <= wdata_i[EVT_W-1:0];
  end

  always_comb begin
    rd_d = '0;
    if (rd_en_i) begin
      if (hit_mask)   rd_d[EVT_W-1:0] = mask_q;
      if (hit_status) rd_d[EVT_W-1:0] = status_q;
      if (hit_done)   rd_d[DBIT]      = done_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      rdata_o <= rd_d;
      irq_o   <= (|(status_q & mask_q)) | status_q[BYP];
    end
  end
endmodule

// File: rtl/irq_unit_checker.sv
module irq_unit_checker #(
  parameter int EVT_W = 8,
  parameter int ALT   = 0
) (
  input logic             clk,
  input logic             rst,
  input logic [EVT_W-1:0] evt,
  input logic             clr_en,
  input logic [EVT_W-1:0] clr_bits,
  input logic [EVT_W-1:0] status,
  input logic [EVT_W-1:0] mask,
  input logic             irq,
  input logic             done
);
  localparam int BYP = irq_regs_pkg::EV_PKT_DONE;

  a_r1_latch: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((status & $past(evt)) == $past(evt)));

  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_en && ((clr_bits & ~evt) != '0)) |=>
      ((status & $past(clr_bits & ~evt)) == '0));

  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_en |=> ((status & $past(status)) == $past(status)));

  a_r4_irq_on: assert property (@(posedge clk) disable iff (rst)
    ((status & mask) != '0) |=> irq);

  a_r5_bypass: assert property (@(posedge clk) disable iff (rst)
    status[BYP] |=> irq);

  a_r4_irq_off: assert property (@(posedge clk) disable iff (rst)
    (((status & mask) == '0) && !status[BYP]) |=> !irq);

  generate
    if (ALT != 0) begin : g_alt
      a_r8_done_set: assert property (@(posedge clk) disable iff (rst)
        evt[BYP] |=> done);
    end else begin : g_nat
      a_r8_done_absent: assert property (@(posedge clk) disable iff (rst)
        !done);
    end
  endgenerate
endmodule

bind irq_status_unit irq_unit_checker #(.EVT_W(EVT_W), .ALT(ALT_LAYOUT)) u_chk (
  .clk(clk), .rst(rst), .evt(evt_i), .clr_en(status_clr),
  .clr_bits(wdata_i[EVT_W-1:0]), .status(status_q), .mask(mask_q),
  .irq(irq_o), .done(done_q)
);

// File: tb/sim_irq_status_unit.sv
module sim_irq_status_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  evt = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  addr_n, addr_a;
  logic [31:0] rdata_n, rdata_a;
  logic        irq_n, irq_a;

  int    nchk = 0, nbad = 0;
  string cur_tag = "R6";

  always #2 clk = ~clk;

  // sel: 0 mask, 1 status, 2 done register, 3 unmapped hole
  function automatic logic [7:0] map_addr(input int alt, input logic [1:0] s);
    case (s)
      2'd0: return alt ? 8'h74 : 8'h64;
      2'd1: return alt ? 8'h78 : 8'h68;
      2'd2: return 8'h0C;
      default: return 8'h20;
    endcase
  endfunction

  assign addr_n = map_addr(0, sel);
  assign addr_a = map_addr(1, sel);

  irq_status_unit #(.ALT_LAYOUT(0)) u0 (
    .clk(clk), .rst(rst), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr_n), .wdata_i(wdata), .rdata_o(rdata_n), .irq_o(irq_n));

  irq_status_unit #(.ALT_LAYOUT(1)) u1 (
    .clk(clk), .rst(rst), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr_a), .wdata_i(wdata), .rdata_o(rdata_a), .irq_o(irq_a));

  // Reference model, index 0 native, 1 alternate
  logic [7:0]  st_m [2];
  logic [7:0]  mk_m [2];
  logic        dn_m [2];
  logic [31:0] rd_m [2];
  logic        irq_m [2];

  function automatic logic [31:0] read_exp(input int l);
    logic [31:0] v = '0;
    case (sel)
      2'd0: v[7:0] = mk_m[l];
      2'd1: v[7:0] = st_m[l];
      2'd2: v[30]  = (l == 1) ? dn_m[l] : 1'b0;
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    for (int l = 0; l < 2; l++) begin
      if (rst) begin
        st_m[l] <= '0; mk_m[l] <= '0; dn_m[l] <= 1'b0;
        rd_m[l] <= '0; irq_m[l] <= 1'b0;
      end else begin
        rd_m[l]  <= rd_en ? read_exp(l) : 32'h0;
        irq_m[l] <= (|(st_m[l] & mk_m[l])) | st_m[l][7];
        if (wr_en && sel == 2'd1) st_m[l] <= (st_m[l] & ~wdata[7:0]) | evt;
        else                      st_m[l] <= st_m[l] | evt;
        if (wr_en && sel == 2'd0) mk_m[l] <= wdata[7:0];
        if (l == 1) begin
          if (evt[7]) dn_m[l] <= 1'b1;
          else if (wr_en && sel == 2'd2 && wdata[30]) dn_m[l] <= 1'b0;
        end
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("native rdata", rdata_n, rd_m[0]);
    chk("alt rdata",    rdata_a, rd_m[1]);
    chk("native irq",   {31'b0, irq_n}, {31'b0, irq_m[0]});
    chk("alt irq",      {31'b0, irq_a}, {31'b0, irq_m[1]});
  endtask

  task automatic cyc(input logic [7:0] e, input logic w, input logic r,
                     input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    compare_all();
    evt = e; wr_en = w; rd_en = r; sel = s; wdata = d;
  endtask

  task automatic rd(input logic [1:0] s);  cyc(8'h00, 1'b0, 1'b1, s, 32'h0); endtask
  task automatic wr(input logic [1:0] s, input logic [31:0] d); cyc(8'h00, 1'b1, 1'b0, s, d); endtask
  task automatic idle(); cyc(8'h00, 1'b0, 1'b0, 2'd0, 32'h0); endtask

  initial begin
    #(4 * 100000);
    nbad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R6: reset values seen at the ports
    cur_tag = "R6";
    chk("irq after reset", {30'b0, irq_a, irq_n}, 32'h0);
    rd(2'd0); rd(2'd1); rd(2'd2); idle();

    // R1: each event bit latches into its own position
    cur_tag = "R1";
    for (int b = 0; b < 8; b++) begin
      cyc(8'(1 << b), 1'b0, 1'b0, 2'd0, 32'h0);
      idle(); rd(2'd1); idle();
      wr(2'd1, 32'hFF); idle();
    end

    // R2: write-one-to-clear, zeros leave bits alone
    cur_tag = "R2";
    cyc(8'hA5, 1'b0, 1'b0, 2'd0, 32'h0);
    wr(2'd1, 32'h0); rd(2'd1);
    wr(2'd1, 32'h0F); rd(2'd1);
    wr(2'd1, 32'hFF); rd(2'd1); idle();

    // R3: event and clear of the same bit in one cycle
    cur_tag = "R3";
    cyc(8'h01, 1'b0, 1'b0, 2'd0, 32'h0);
    cyc(8'h01, 1'b1, 1'b0, 2'd1, 32'h01); rd(2'd1);
    cyc(8'h02, 1'b1, 1'b0, 2'd1, 32'h03); rd(2'd1);
    wr(2'd1, 32'hFF); idle();

    // R4: mask gates the interrupt
    cur_tag = "R4";
    wr(2'd0, 32'h0C);
    cyc(8'h10, 1'b0, 1'b0, 2'd0, 32'h0); idle(); idle();
    cyc(8'h04, 1'b0, 1'b0, 2'd0, 32'h0); idle(); idle();
    wr(2'd1, 32'h04); idle(); idle();
    wr(2'd1, 32'hFF); idle();

    // R5: packet-complete bypasses the mask
    cur_tag = "R5";
    wr(2'd0, 32'h00);
    cyc(8'h80, 1'b0, 1'b0, 2'd0, 32'h0); idle(); idle();
    wr(2'd1, 32'h80); idle(); idle();

    // R7: address layouts and readback
    cur_tag = "R7";
    wr(2'd0, 32'hFFFF_FF5A); rd(2'd0);
    cyc(8'h33, 1'b0, 1'b0, 2'd0, 32'h0); rd(2'd1);
    wr(2'd1, 32'hFF); wr(2'd0, 32'h0); idle();

    // R8: done flag, alternate layout only
    cur_tag = "R8";
    rd(2'd2);
    cyc(8'h80, 1'b0, 1'b0, 2'd0, 32'h0); rd(2'd2);
    wr(2'd2, 32'h0000_0001); rd(2'd2);
    wr(2'd2, 32'h4000_0000); rd(2'd2);
    cyc(8'h80, 1'b0, 1'b0, 2'd0, 32'h0);
    cyc(8'h80, 1'b1, 1'b0, 2'd2, 32'h4000_0000); rd(2'd2);
    wr(2'd2, 32'h4000_0000); rd(2'd2);
    wr(2'd1, 32'hFF); idle();

    // R9: holes and read timing
    cur_tag = "R9";
    wr(2'd0, 32'h81);
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3); rd(2'd0); idle();
    wr(2'd0, 32'h0); idle();

    // Random mix across all registers
    cur_tag = "R2 random";
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  e;
      logic [31:0] d;
      e = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      d = $urandom;
      if (($urandom % 3) == 0) d[30] = 1'b1;
      cyc(e, 1'(($urandom % 3) == 0), 1'($urandom), 2'($urandom), d);
    end
    idle(); idle();

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule